// File: doc/BRIEF.md
# UART Receive Error Status Register

This block keeps the sticky receive-side error flags of a UART and the receiver enable bit. The receiver and transmitter report error events on single-cycle strobes: parity, framing, receive underrun, receive overrun, transmit overrun and line break. Each strobe sets its flag, and the flag stays set until software clears it. Software cannot write the status word directly. It changes flags only through a write-only command word. In that word every flag has one bit that clears it and one bit that sets it, and the receiver enable has a clear bit and a set bit of its own.

A read-only status word shows the receiver enable and all six flags. A level interrupt output is the OR of the six error flags. The block applies a fixed precedence when several sources touch one flag in the same cycle: a hardware event or a software set beats a software clear. This keeps an error that arrives while software is acknowledging older ones. While the receiver is disabled, the parity, framing and break strobes are ignored.

Top module: `uart_err_status`

## Requirements
- R1: After a synchronous active-low reset, receiver enable is 0, all six error flags are 0, the status word reads 0 and `err_irq` is 0.
- R2: A command write with bit 0 set clears the receiver enable and one with bit 1 set sets it. If both bits are set, the set wins. The enable is visible on `rx_en` and on status bit 0 from the cycle after the write.
- R3: The status word holds parity error at bit 16, framing error at bit 17, receive underrun at bit 18, receive overrun at bit 19, transmit overrun at bit 20 and break at bit 21. All bits other than 0 and 16 to 21 read 0.
- R4: Command bits 2 to 7 clear, in this order, parity, framing, receive underrun, receive overrun, transmit overrun and break. The value 0xFC clears all six flags at once and leaves the receiver enable unchanged.
- R5: Command bits 8 to 13 set the same six flags, in the same order as R4.
- R6: Zero bits in a command write leave their flags and the enable unchanged. Without a command write or an event, no flag changes.
- R7: An event strobe sets its flag in the next cycle. If a software clear of the same flag arrives in the same cycle, the event wins.
- R8: When the set bit and the clear bit of one flag are both 1 in a single command, the flag ends up set.
- R9: `err_irq` is high exactly while at least one of the six error flags is set. It stays high until every set flag has been cleared.
- R10: While the receiver enable is 0, parity, framing and break strobes have no effect. Underrun and both overrun strobes are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word: per-flag clear and set bits |
| ev_parity | input | 1 | Parity error strobe from the receiver |
| ev_frame | input | 1 | Framing error strobe from the receiver |
| ev_rx_under | input | 1 | Receive underrun strobe |
| ev_rx_over | input | 1 | Receive overrun strobe |
| ev_tx_over | input | 1 | Transmit overrun strobe |
| ev_break | input | 1 | Line break strobe from the receiver |
| status_word | output | 32 | Read-only status: enable at bit 0, flags at bits 16 to 21 |
| rx_en | output | 1 | Receiver enable |
| err_irq | output | 1 | OR of the six error flags |

## Verification
The bench targets same-cycle collisions. In one case an event meets a clear of its own flag; a design that let the clear win would lose that error. In another, a command carries both the set and the clear bit of one flag; a design with the wrong precedence would leave the flag cleared. The clear-all value 0xFC is applied while the receiver is enabled, to catch a decoder that reaches bit 0 or 1 and drops the enable. Parity, framing and break strobes are sent while the receiver is disabled, together with overrun strobes; a missing gate would raise flags and the interrupt that should stay low. A decoder with one bit position shifted would clear or set the neighbouring flag, and the per-flag set and clear patterns catch that.

// File: rtl/uart_err_pkg.sv
// Package: shared constants for the UART error status block.
// Assumes: flag index i maps to status bit STAT_LSB+i, clear bit CLR_LSB+i
//          and set bit SET_LSB+i; the positions are fixed by software.
package uart_err_pkg;
    localparam int NUM_FLAGS   = 6;
    localparam int WORD_W      = 32;
    localparam int EN_CLR_BIT  = 0;
    localparam int EN_SET_BIT  = 1;
    localparam int CLR_LSB     = 2;
    localparam int SET_LSB     = CLR_LSB + NUM_FLAGS;
    localparam int STAT_EN_BIT = 0;
    localparam int STAT_LSB    = 16;

    typedef enum logic [2:0] {
        FLG_PARITY   = 3'd0,
        FLG_FRAME    = 3'd1,
        FLG_RX_UNDER = 3'd2,
        FLG_RX_OVER  = 3'd3,
        FLG_TX_OVER  = 3'd4,
        FLG_BREAK    = 3'd5
    } flag_idx_e;

    // Flags that only the receive line can raise; these are gated by enable.
    localparam logic [NUM_FLAGS-1:0] RX_LINE_MASK =
        (NUM_FLAGS'(1) << FLG_PARITY) | (NUM_FLAGS'(1) << FLG_FRAME) |
        (NUM_FLAGS'(1) << FLG_BREAK);
endpackage

// File: rtl/err_cmd_decode.sv
// Module: err_cmd_decode
// Splits a command write into per-flag clear/set vectors and enable controls,
// and gates receive-line events while the receiver is disabled.
// Assumes: cmd_we is a single-cycle strobe; events are single-cycle strobes.
module err_cmd_decode
    import uart_err_pkg::*;
#(
    parameter int N = NUM_FLAGS,
    parameter int W = WORD_W
) (
    input  logic         cmd_we,
    input  logic [W-1:0] cmd_wdata,
    input  logic [N-1:0] evt_raw,
    input  logic         rx_en_q,
    output logic [N-1:0] sw_clr,
    output logic [N-1:0] sw_set,
    output logic [N-1:0] evt_gated,
    output logic         en_clr,
    output logic         en_set
);
    // Decode the command fields into strobes.
    always_comb begin
        sw_clr = cmd_we ? cmd_wdata[CLR_LSB +: N] : '0;
        sw_set = cmd_we ? cmd_wdata[SET_LSB +: N] : '0;
        en_clr = cmd_we & cmd_wdata[EN_CLR_BIT];
        en_set = cmd_we & cmd_wdata[EN_SET_BIT];
    end

    // Suppress receive-line events while the receiver is off.
    always_comb begin
        evt_gated = rx_en_q ? evt_raw : (evt_raw & ~RX_LINE_MASK[N-1:0]);
    end
endmodule

// File: rtl/err_flag_cell.sv
// Module: err_flag_cell
// One sticky error flag. A hardware event or a software set beats a
// software clear in the same cycle.
// Assumes: synchronous active-low reset; inputs are single-cycle strobes.
module err_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_set,
    input  logic sw_clr,
    output logic flag
);
    // Update the sticky flag with set-over-clear precedence.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (hw_set || sw_set)
            flag <= 1'b1;
        else if (sw_clr)
            flag <= 1'b0;
    end

    // R7: an event always lands, even against a clear.
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> flag);
    // R8: a set in the same command as a clear wins.
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set && sw_clr) |=> flag);
    // R4: a lone clear drops the flag.
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !sw_set && !hw_set) |=> !flag);
    // R6: nothing touching the flag keeps it.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_clr && !sw_set && !hw_set) |=> $stable(flag));
endmodule

// File: rtl/rx_en_reg.sv
// Module: rx_en_reg
// The receiver enable bit; the set command takes precedence over the clear.
// Assumes: synchronous active-low reset to disabled.
module rx_en_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic en_clr,
    output logic en_q
);
    // Hold or change the enable on command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (en_set)
            en_q <= 1'b1;
        else if (en_clr)
            en_q <= 1'b0;
    end

    // R2: the enable follows its command bits.
    a_r2_en_set: assert property (@(posedge clk) disable iff (!rst_n)
        en_set |=> en_q);
    a_r2_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr && !en_set) |=> !en_q);
endmodule

// File: rtl/uart_err_status.sv
// Module: uart_err_status (top)
// Sticky UART error flags and receiver enable, changed by hardware events and
// a write-only set/clear command word; exposes a status word and an interrupt.
// Assumes: one clock domain, synchronous active-low reset.
module uart_err_status
    import uart_err_pkg::*;
#(
    parameter int N = NUM_FLAGS,
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_we,
    input  logic [W-1:0] cmd_wdata,
    input  logic         ev_parity,
    input  logic         ev_frame,
    input  logic         ev_rx_under,
    input  logic         ev_rx_over,
    input  logic         ev_tx_over,
    input  logic         ev_break,
    output logic [W-1:0] status_word,
    output logic         rx_en,
    output logic         err_irq
);
    logic [N-1:0] evt_raw, evt_gated, sw_clr, sw_set, flags;
    logic         en_clr, en_set;

    // Collect event strobes in flag-index order.
    always_comb begin
        evt_raw                = '0;
        evt_raw[FLG_PARITY]    = ev_parity;
        evt_raw[FLG_FRAME]     = ev_frame;
        evt_raw[FLG_RX_UNDER]  = ev_rx_under;
        evt_raw[FLG_RX_OVER]   = ev_rx_over;
        evt_raw[FLG_TX_OVER]   = ev_tx_over;
        evt_raw[FLG_BREAK]     = ev_break;
    end

    err_cmd_decode #(.N(N), .W(W)) u_dec (
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .evt_raw   (evt_raw),
        .rx_en_q   (rx_en),
        .sw_clr    (sw_clr),
        .sw_set    (sw_set),
        .evt_gated (evt_gated),
        .en_clr    (en_clr),
        .en_set    (en_set)
    );

    rx_en_reg u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_set (en_set),
        .en_clr (en_clr),
        .en_q   (rx_en)
    );

    for (genvar i = 0; i < N; i++) begin : g_flag
        err_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (evt_gated[i]),
            .sw_set (sw_set[i]),
            .sw_clr (sw_clr[i]),
            .flag   (flags[i])
        );
    end

    // Assemble the read-only status word.
    always_comb begin
        status_word               = '0;
        status_word[STAT_EN_BIT]  = rx_en;
        status_word[STAT_LSB +: N] = flags;
    end

    // Raise the error interrupt from any set flag.
    always_comb err_irq = |flags;

    // R9: the interrupt only rises after an event or a software set.
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_irq) |-> $past(|(evt_gated | sw_set)));
    // R10: a parity strobe while disabled does not raise a clear flag.
    a_r10_parity_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && ev_parity && !status_word[STAT_LSB + FLG_PARITY] &&
         !(cmd_we && cmd_wdata[SET_LSB + FLG_PARITY]))
        |=> !status_word[STAT_LSB + FLG_PARITY]);
    // R10: a break strobe while disabled does not raise a clear flag.
    a_r10_break_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && ev_break && !status_word[STAT_LSB + FLG_BREAK] &&
         !(cmd_we && cmd_wdata[SET_LSB + FLG_BREAK]))
        |=> !status_word[STAT_LSB + FLG_BREAK]);
endmodule

// File: tb/uart_err_status_tb.sv
// Scoreboard bench: the driver applies one cycle of stimulus, updates a
// reference model built from the requirements and queues the expected
// outputs; the monitor pops and compares at the following falling edge.
module uart_err_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [5:0]  ev = '0;
    logic [31:0] status_word;
    logic        rx_en, err_irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] st;
        logic        irq;
        logic        en;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [5:0] m_flags = '0;
    logic       m_en = 1'b0;

    always #4 clk = ~clk;

    uart_err_status u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .ev_parity(ev[0]), .ev_frame(ev[1]), .ev_rx_under(ev[2]),
        .ev_rx_over(ev[3]), .ev_tx_over(ev[4]), .ev_break(ev[5]),
        .status_word(status_word), .rx_en(rx_en), .err_irq(err_irq)
    );

    // Driver: one cycle of stimulus; model update; queue the expected outputs.
    task automatic step(input bit we, input logic [31:0] d, input logic [5:0] e,
                        input string tag);
        logic [5:0] evm, nf;
        logic       ne;
        @(negedge clk);
        cmd_we = we; cmd_wdata = d; ev = e;
        evm = m_en ? e : (e & 6'b011100);
        nf  = m_flags;
        if (we) nf = nf & ~d[7:2];
        nf = nf | evm | (we ? d[13:8] : 6'b0);
        ne = m_en;
        if (we && d[0]) ne = 1'b0;
        if (we && d[1]) ne = 1'b1;
        m_flags = nf; m_en = ne;
        @(posedge clk);
        q.push_back('{{10'b0, nf, 15'b0, ne}, |nf, ne, tag});
    endtask

    // Monitor: compare after each capturing edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            n_chk++;
            if (status_word !== x.st || err_irq !== x.irq || rx_en !== x.en) begin
                n_fail++;
                $display("FAIL %s: status=%h irq=%b en=%b expected status=%h irq=%b en=%b",
                         x.tag, status_word, err_irq, rx_en, x.st, x.irq, x.en);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;  // R1 reset state
        if (status_word !== 32'h0 || err_irq !== 1'b0 || rx_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: status=%h irq=%b en=%b expected 0 0 0", status_word, err_irq, rx_en);
        end
        rst_n = 1'b1;
        // R10: line errors ignored while disabled; overruns/underrun still land
        step(0, 32'h0, 6'b100011, "R10 gated line events");
        step(0, 32'h0, 6'b011100, "R10 overruns recorded while disabled");
        step(1, 32'h0000_00FC, 6'b0, "R4 clear all");
        step(1, 32'h0000_0002, 6'b0, "R2 enable set");
        // R3/R7: each event lands at its own status bit
        for (int i = 0; i < 6; i++) begin
            step(0, 32'h0, 6'(1 << i), "R3 R7 event position");
        end
        step(1, 32'h0000_00FC, 6'b0, "R4 clear all keeps enable");
        // R5: set bits one at a time
        step(1, 32'h0000_0100, 6'b0, "R5 set parity");
        step(1, 32'h0000_2000, 6'b0, "R5 set break");
        step(1, 32'h0000_0800, 6'b0, "R5 set rx overrun");
        // R9: irq stays up until the last flag is cleared
        step(1, 32'h0000_0004, 6'b0, "R4 R9 clear parity only");
        step(1, 32'h0000_0080, 6'b0, "R4 R9 clear break only");
        step(1, 32'h0000_0020, 6'b0, "R9 clear last flag");
        // R6: write of zero and idle cycle
        step(1, 32'h0000_0400, 6'b0, "R5 set rx underrun");
        step(1, 32'h0000_0000, 6'b0, "R6 zero write");
        step(0, 32'hFFFF_FFFF, 6'b0, "R6 data without strobe");
        // R7: event beats a clear of the same flag
        step(1, 32'h0000_00FC, 6'b000010, "R7 event beats clear");
        // R8: set and clear together
        step(1, 32'h0000_1040, 6'b0, "R8 set beats clear");
        step(1, 32'h0000_00FC, 6'b0, "R4 clear all");
        // R2: disable; both enable bits set -> set wins
        step(1, 32'h0000_0001, 6'b0, "R2 enable clear");
        step(0, 32'h0, 6'b100001, "R10 gated after disable");
        step(1, 32'h0000_0003, 6'b0, "R2 both enable bits");
        step(0, 32'h0, 6'b100000, "R10 break recorded when enabled");
        step(0, 32'h0, 6'b0, "R6 idle");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule